// File: doc/BRIEF.md
# Egress Queue Scheduler with Priority Map

This block decides which transmit queue of a single switch egress port sends the next frame. It also classifies arriving frames: each frame's 3-bit traffic-class priority is looked up in a programmable table, and the table returns the queue the frame belongs in. Frame storage lives elsewhere. The scheduler sees only one non-empty flag per queue and a pulse that marks the end of the frame currently being sent.

Each queue runs in one of two modes, strict priority or weighted round robin. In weighted round robin, a queue's weight is a packet count. A write-only register port configures the block. The per-queue mode and weight are reached through a queue-select register, so a mode or weight write affects only the queue currently selected. Per-queue egress rate limits are held in shadow registers and take effect together. The block does not shape traffic by these limits. An active nonzero limit only switches arbitration to plain round robin.

Top module: `egress_sched_top`

## Requirements
- R1: When no rate limit is active and any non-empty queue is in strict mode (mode bit 1), the grant goes to the highest-indexed non-empty strict queue. Strict queues win over every weighted queue.
- R2: The queue-select register (address 0, value in the low index bits) chooses which queue a mode write (address 1, bit 0: 1 = strict, 0 = weighted) or a weight write (address 2, bits [7:0]) changes. No other queue's mode or weight changes.
- R3: Weighted queues are served in ascending index order with wrap-around. The search starts after the last weighted queue served and skips empty queues. On a new turn, a queue may send up to its weight in frames back to back.
- R4: A weight of 0 behaves as a weight of 1.
- R5: After reset, no grant is issued and every queue is weighted with weight 1. The map sends priority p to queue p >> s, where s is 2 for two queues, 1 for four queues and 0 for eight queues. The limits are 0.
- R6: The map register (address 3) holds eight 4-bit fields. The field for priority p is at bits [4p+3:4p]. The queue for an arriving frame is the low log2(queues) bits of its field, and it is available combinationally.
- R7: A rate-limit write (address 8+q) goes to a shadow register. All shadow values become active only when queue NUM_Q-1's limit is written.
- R8: While any active limit is nonzero, grants follow plain round robin in ascending order among non-empty queues. Modes and weights are ignored in this state.
- R9: A grant stays fixed and valid from its start until the frame-done pulse. The next grant appears no earlier than the second clock edge after the pulse.
- R10: A grant is issued only to a queue whose non-empty flag was set in the cycle the grant was taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration register address |
| cfg_wdata | input | 32 | Configuration write data |
| q_nonempty | input | NUM_Q | One flag per queue, set while the queue holds a frame |
| frame_done | input | 1 | Pulse ending the frame of the current grant |
| arr_prio | input | 3 | Traffic-class priority of the arriving frame |
| arr_queue | output | log2(NUM_Q) | Queue selected for the arriving frame |
| grant_valid | output | 1 | A queue currently holds the grant |
| grant_q | output | log2(NUM_Q) | Index of the granted queue |

## Verification
On every cycle, the assertions check three things. A grant holds still until the frame-done pulse and is followed by a free cycle. Every new grant goes to a queue that was non-empty. When no limit is active, a new grant goes to the highest non-empty strict queue whenever one exists. The bench's scenarios cover the rest: the order of weighted service, reloading of the packet count, weight 0 and the per-queue effect of the queue-select register. They also cover the default and programmed priority map, and the way shadow rate limits stay idle until the last queue's limit is written and then force plain round robin.

// File: rtl/sched_pkg.sv
package sched_pkg;

    typedef enum logic {
        MODE_WRR    = 1'b0,
        MODE_STRICT = 1'b1
    } qmode_e;

    typedef enum logic [2:0] {
        PK_NONE     = 3'd0,
        PK_STRICT   = 3'd1,
        PK_WRR_CONT = 3'd2,
        PK_WRR_NEW  = 3'd3,
        PK_PLAIN_RR = 3'd4
    } pick_kind_e;

    localparam int PRIO_N  = 8;
    localparam int FIELD_W = 4;
    localparam int MAP_W   = PRIO_N * FIELD_W;
    localparam int ADDR_W  = 4;
    localparam int DATA_W  = 32;

    localparam logic [ADDR_W-1:0] ADDR_QSEL   = 4'h0;
    localparam logic [ADDR_W-1:0] ADDR_MODE   = 4'h1;
    localparam logic [ADDR_W-1:0] ADDR_WEIGHT = 4'h2;
    localparam logic [ADDR_W-1:0] ADDR_MAP    = 4'h3;

    typedef struct packed {
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } cfg_wr_t;

    function automatic int map_shift(input int nq);
        if (nq == 2) return 2;
        if (nq == 4) return 1;
        return 0;
    endfunction

    function automatic logic [MAP_W-1:0] default_map(input int nq);
        logic [MAP_W-1:0] m;
        m = '0;
        for (int p = 0; p < PRIO_N; p++) begin
            m[p*FIELD_W +: FIELD_W] = FIELD_W'(p >> map_shift(nq));
        end
        return m;
    endfunction

endpackage

// File: rtl/sched_cfg_regs.sv
module sched_cfg_regs
    import sched_pkg::*;
#(
    parameter int NUM_Q    = 4,
    parameter int WEIGHT_W = 8,
    parameter int RATE_W   = 8,
    localparam int QW      = $clog2(NUM_Q)
) (
    input  logic                             clk,
    input  logic                             rst,
    input  cfg_wr_t                          wr,
    output logic [NUM_Q-1:0]                 strict_mask,
    output logic [NUM_Q-1:0][WEIGHT_W-1:0]   weight,
    output logic [MAP_W-1:0]                 prio_map,
    output logic                             limit_on
);

    logic [QW-1:0]                   qsel;
    qmode_e                          mode [NUM_Q];
    logic [NUM_Q-1:0][RATE_W-1:0]    shadow;
    logic                            rate_wr;
    logic [QW-1:0]                   ridx;
    logic                            any_nz_next;
    logic                            unused_bits;

    assign rate_wr = wr.we && wr.addr[3] && (int'(wr.addr[2:0]) < NUM_Q);
    assign ridx    = wr.addr[QW-1:0];
    assign unused_bits = ^{wr.data[DATA_W-1:RATE_W], wr.data[DATA_W-1:WEIGHT_W]};

    always_comb begin
        any_nz_next = 1'b0;
        for (int q = 0; q < NUM_Q; q++) begin
            if (QW'(q) == ridx) any_nz_next = any_nz_next | (wr.data[RATE_W-1:0] != '0);
            else                any_nz_next = any_nz_next | (shadow[q] != '0);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            qsel     <= '0;
            prio_map <= default_map(NUM_Q);
            for (int q = 0; q < NUM_Q; q++) begin
                mode[q]   <= MODE_WRR;
                weight[q] <= WEIGHT_W'(1);
            end
        end else if (wr.we) begin
            case (wr.addr)
                ADDR_QSEL:   qsel         <= wr.data[QW-1:0];
                ADDR_MODE:   mode[qsel]   <= qmode_e'(wr.data[0]);
                ADDR_WEIGHT: weight[qsel] <= wr.data[WEIGHT_W-1:0];
                ADDR_MAP:    prio_map     <= wr.data[MAP_W-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow   <= '0;
            limit_on <= 1'b0;
        end else if (rate_wr) begin
            shadow[ridx] <= wr.data[RATE_W-1:0];
            if (ridx == QW'(NUM_Q-1)) limit_on <= any_nz_next;
        end
    end

    always_comb begin
        for (int q = 0; q < NUM_Q; q++) strict_mask[q] = (mode[q] == MODE_STRICT);
    end

endmodule

// File: rtl/sched_pick.sv
module sched_pick
    import sched_pkg::*;
#(
    parameter int NUM_Q = 4,
    localparam int QW   = $clog2(NUM_Q)
) (
    input  logic [NUM_Q-1:0] q_nonempty,
    input  logic [NUM_Q-1:0] strict_mask,
    input  logic             limit_on,
    input  logic [QW-1:0]    wrr_cur,
    input  logic             wrr_left_nz,
    output logic             pick_valid,
    output logic [QW-1:0]    pick_q,
    output pick_kind_e       pick_kind
);

    logic [NUM_Q-1:0] strict_req;
    logic [NUM_Q-1:0] wrr_req;
    logic [NUM_Q-1:0] rot_mask;
    logic             rot_found;
    logic [QW-1:0]    rot_sel;
    logic             hi_found;
    logic [QW-1:0]    hi_sel;

    assign strict_req = q_nonempty & strict_mask;
    assign wrr_req    = q_nonempty & ~strict_mask;
    assign rot_mask   = limit_on ? q_nonempty : wrr_req;

    // next set bit strictly after wrr_cur, wrapping
    always_comb begin
        rot_found = 1'b0;
        rot_sel   = '0;
        for (int i = NUM_Q; i >= 1; i--) begin
            if (rot_mask[(int'(wrr_cur) + i) % NUM_Q]) begin
                rot_found = 1'b1;
                rot_sel   = QW'((int'(wrr_cur) + i) % NUM_Q);
            end
        end
    end

    always_comb begin
        hi_found = 1'b0;
        hi_sel   = '0;
        for (int i = 0; i < NUM_Q; i++) begin
            if (strict_req[i]) begin
                hi_found = 1'b1;
                hi_sel   = QW'(i);
            end
        end
    end

    always_comb begin
        pick_valid = 1'b0;
        pick_q     = '0;
        pick_kind  = PK_NONE;
        if (limit_on) begin
            pick_valid = rot_found;
            pick_q     = rot_sel;
            pick_kind  = rot_found ? PK_PLAIN_RR : PK_NONE;
        end else if (hi_found) begin
            pick_valid = 1'b1;
            pick_q     = hi_sel;
            pick_kind  = PK_STRICT;
        end else if (wrr_req[wrr_cur] && wrr_left_nz) begin
            pick_valid = 1'b1;
            pick_q     = wrr_cur;
            pick_kind  = PK_WRR_CONT;
        end else if (rot_found) begin
            pick_valid = 1'b1;
            pick_q     = rot_sel;
            pick_kind  = PK_WRR_NEW;
        end
    end

endmodule

// File: rtl/sched_grant.sv
module sched_grant
    import sched_pkg::*;
#(
    parameter int NUM_Q    = 4,
    parameter int WEIGHT_W = 8,
    localparam int QW      = $clog2(NUM_Q)
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           pick_valid,
    input  logic [QW-1:0]                  pick_q,
    input  pick_kind_e                     pick_kind,
    input  logic [NUM_Q-1:0][WEIGHT_W-1:0] eff_weight,
    input  logic                           frame_done,
    output logic                           busy,
    output logic [QW-1:0]                  grant_q,
    output logic [QW-1:0]                  wrr_cur,
    output logic                           wrr_left_nz
);

    logic [WEIGHT_W-1:0] wrr_left;

    assign wrr_left_nz = (wrr_left != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy     <= 1'b0;
            grant_q  <= '0;
            wrr_cur  <= QW'(NUM_Q-1);
            wrr_left <= '0;
        end else if (busy) begin
            if (frame_done) busy <= 1'b0;
        end else if (pick_valid) begin
            busy    <= 1'b1;
            grant_q <= pick_q;
            case (pick_kind)
                PK_WRR_CONT: wrr_left <= wrr_left - 1'b1;
                PK_WRR_NEW: begin
                    wrr_cur  <= pick_q;
                    wrr_left <= eff_weight[pick_q] - 1'b1;
                end
                PK_PLAIN_RR: begin
                    wrr_cur  <= pick_q;
                    wrr_left <= '0;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/egress_sched_top.sv
module egress_sched_top
    import sched_pkg::*;
#(
    parameter int NUM_Q    = 4,
    parameter int WEIGHT_W = 8,
    parameter int RATE_W   = 8,
    localparam int QW      = $clog2(NUM_Q)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [3:0]        cfg_addr,
    input  logic [31:0]       cfg_wdata,
    input  logic [NUM_Q-1:0]  q_nonempty,
    input  logic              frame_done,
    input  logic [2:0]        arr_prio,
    output logic [QW-1:0]     arr_queue,
    output logic              grant_valid,
    output logic [QW-1:0]     grant_q
);

    cfg_wr_t                         wr;
    logic [NUM_Q-1:0]                strict_mask;
    logic [NUM_Q-1:0][WEIGHT_W-1:0]  weight;
    logic [NUM_Q-1:0][WEIGHT_W-1:0]  eff_weight;
    logic [MAP_W-1:0]                prio_map;
    logic                            limit_on;
    logic                            pick_valid;
    logic [QW-1:0]                   pick_q;
    pick_kind_e                      pick_kind;
    logic [QW-1:0]                   wrr_cur;
    logic                            wrr_left_nz;

    assign wr = '{we: cfg_we, addr: cfg_addr, data: cfg_wdata};

    generate
        for (genvar q = 0; q < NUM_Q; q++) begin : g_weight
            assign eff_weight[q] = (weight[q] == '0) ? WEIGHT_W'(1) : weight[q];
        end
    endgenerate

    assign arr_queue = prio_map[{arr_prio, 2'b00} +: QW];

    sched_cfg_regs #(.NUM_Q(NUM_Q), .WEIGHT_W(WEIGHT_W), .RATE_W(RATE_W)) u_cfg (
        .clk         (clk),
        .rst         (rst),
        .wr          (wr),
        .strict_mask (strict_mask),
        .weight      (weight),
        .prio_map    (prio_map),
        .limit_on    (limit_on)
    );

    sched_pick #(.NUM_Q(NUM_Q)) u_pick (
        .q_nonempty  (q_nonempty),
        .strict_mask (strict_mask),
        .limit_on    (limit_on),
        .wrr_cur     (wrr_cur),
        .wrr_left_nz (wrr_left_nz),
        .pick_valid  (pick_valid),
        .pick_q      (pick_q),
        .pick_kind   (pick_kind)
    );

    sched_grant #(.NUM_Q(NUM_Q), .WEIGHT_W(WEIGHT_W)) u_grant (
        .clk         (clk),
        .rst         (rst),
        .pick_valid  (pick_valid),
        .pick_q      (pick_q),
        .pick_kind   (pick_kind),
        .eff_weight  (eff_weight),
        .frame_done  (frame_done),
        .busy        (grant_valid),
        .grant_q     (grant_q),
        .wrr_cur     (wrr_cur),
        .wrr_left_nz (wrr_left_nz)
    );

endmodule

// File: rtl/sched_checks.sv
module sched_checks #(
    parameter int NUM_Q = 4,
    localparam int QW   = $clog2(NUM_Q)
) (
    input logic             clk,
    input logic             rst,
    input logic [NUM_Q-1:0] q_nonempty,
    input logic             frame_done,
    input logic             grant_valid,
    input logic [QW-1:0]    grant_q,
    input logic [NUM_Q-1:0] strict_mask,
    input logic             limit_on
);

    logic [NUM_Q-1:0] ne_d;
    logic [NUM_Q-1:0] sm_d;
    logic             lim_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            ne_d  <= '0;
            sm_d  <= '0;
            lim_d <= 1'b0;
        end else begin
            ne_d  <= q_nonempty;
            sm_d  <= strict_mask;
            lim_d <= limit_on;
        end
    end

    // R9
    grant_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (grant_valid && !frame_done) |=> (grant_valid && $stable(grant_q)));

    // R9
    grant_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (grant_valid && frame_done) |=> !grant_valid);

    // R10
    grant_nonempty_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(grant_valid) |-> ne_d[grant_q]);

    // R1
    strict_top_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(grant_valid) && !lim_d && (|(ne_d & sm_d)))
        |-> (((ne_d & sm_d) >> grant_q) == NUM_Q'(1)));

endmodule

bind egress_sched_top sched_checks #(.NUM_Q(NUM_Q)) u_sched_checks (
    .clk         (clk),
    .rst         (rst),
    .q_nonempty  (q_nonempty),
    .frame_done  (frame_done),
    .grant_valid (grant_valid),
    .grant_q     (grant_q),
    .strict_mask (strict_mask),
    .limit_on    (limit_on)
);

// File: tb/tb_egress_sched_top.sv
module tb_egress_sched_top;

    localparam int CLK_PERIOD = 10;
    localparam int NQ = 4;
    localparam int QW = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_we = 1'b0;
    logic [3:0]    cfg_addr = '0;
    logic [31:0]   cfg_wdata = '0;
    logic [NQ-1:0] q_nonempty = '0;
    logic          frame_done = 1'b0;
    logic [2:0]    arr_prio = '0;
    logic [QW-1:0] arr_queue;
    logic          grant_valid;
    logic [QW-1:0] grant_q;

    int n_checks = 0;
    int n_fail   = 0;
    bit sink_en  = 1'b0;
    bit prev_gv  = 1'b0;
    bit done     = 1'b0;
    int    exp_q[$];
    string exp_tag[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    egress_sched_top #(.NUM_Q(NQ)) dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .q_nonempty(q_nonempty), .frame_done(frame_done),
        .arr_prio(arr_prio), .arr_queue(arr_queue),
        .grant_valid(grant_valid), .grant_q(grant_q)
    );

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    // sink: finishes each granted frame one cycle after it is seen
    always @(negedge clk) begin
        if (sink_en && grant_valid && !frame_done) frame_done <= 1'b1;
        else frame_done <= 1'b0;
    end

    // monitor: compares each new grant against the scoreboard
    always @(negedge clk) begin
        if (rst) prev_gv = 1'b0;
        else begin
            if (grant_valid && !prev_gv && exp_q.size() > 0) begin
                int e;
                string t;
                e = exp_q.pop_front();
                t = exp_tag.pop_front();
                check(int'(grant_q) == e, t, int'(grant_q), e);
            end
            prev_gv = grant_valid;
        end
    end

    task automatic push(input int q, input string tag);
        exp_q.push_back(q);
        exp_tag.push_back(tag);
    endtask

    task automatic do_reset();
        sink_en    = 1'b0;
        q_nonempty = '0;
        exp_q.delete();
        exp_tag.delete();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic cfg_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic set_mode(input int q, input bit strict);
        cfg_write(4'h0, 32'(q));
        cfg_write(4'h1, {31'd0, strict});
    endtask

    task automatic set_weight(input int q, input int w);
        cfg_write(4'h0, 32'(q));
        cfg_write(4'h2, 32'(w));
    endtask

    task automatic run(input logic [NQ-1:0] ne, input string tag);
        int cnt;
        @(negedge clk);
        q_nonempty = ne;
        sink_en    = 1'b1;
        cnt = 0;
        while (exp_q.size() > 0 && cnt < 500) begin
            @(negedge clk);
            cnt++;
        end
        check(exp_q.size() == 0, {tag, " missing grants"}, exp_q.size(), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        // R5: reset state
        do_reset();
        @(negedge clk);
        check(grant_valid == 1'b0, "R5 no grant after reset", int'(grant_valid), 0);
        for (int p = 0; p < 8; p++) begin
            arr_prio = 3'(p);
            #1;
            check(int'(arr_queue) == (p >> 1), "R5 default map", int'(arr_queue), p >> 1);
        end

        // R3/R5: default weighted round robin, weight 1
        for (int k = 0; k < 8; k++) push(k % 4, "R3 default wrr order");
        run(4'b1111, "R3");

        // R3/R4/R2: packet-count weights 2,0,3,1
        do_reset();
        set_weight(0, 2);
        set_weight(1, 0);
        set_weight(2, 3);
        set_weight(3, 1);
        push(0, "R3 weight q0"); push(0, "R3 weight q0");
        push(1, "R4 zero weight q1");
        push(2, "R2 weight q2"); push(2, "R2 weight q2"); push(2, "R2 weight q2");
        push(3, "R3 weight q3");
        push(0, "R3 reload q0"); push(0, "R3 reload q0");
        run(4'b1111, "R3");

        // R1: strict queues 1 and 3, all busy
        do_reset();
        set_mode(1, 1'b1);
        set_mode(3, 1'b1);
        for (int k = 0; k < 3; k++) push(3, "R1 highest strict");
        run(4'b1111, "R1");

        // R1/R2: queue 3 empty, only queue 1 strict, beats weighted 0 and 2
        do_reset();
        set_mode(1, 1'b1);
        set_mode(3, 1'b1);
        for (int k = 0; k < 3; k++) push(1, "R2 strict only on selected queue");
        run(4'b0111, "R2");

        // R3: strict queue empty, weighted skip of empty queue
        do_reset();
        set_mode(2, 1'b1);
        push(0, "R3 skip empty"); push(1, "R3 skip empty");
        push(3, "R3 skip empty"); push(0, "R3 wrap");
        run(4'b1011, "R3");

        // R7: limit in shadow only, strict still honoured
        do_reset();
        set_mode(3, 1'b1);
        cfg_write(4'h9, 32'd5);
        for (int k = 0; k < 3; k++) push(3, "R7 shadow limit inactive");
        run(4'b1111, "R7");

        // R8: committed limit forces plain round robin
        do_reset();
        set_mode(3, 1'b1);
        set_weight(0, 3);
        cfg_write(4'h9, 32'd5);
        cfg_write(4'hB, 32'd0);
        for (int k = 0; k < 5; k++) push(k % 4, "R8 plain round robin");
        run(4'b1111, "R8");

        // R6: programmed map, fields 7-p, low two bits used
        do_reset();
        cfg_write(4'h3, 32'h0123_4567);
        for (int p = 0; p < 8; p++) begin
            arr_prio = 3'(p);
            #1;
            check(int'(arr_queue) == ((7 - p) & 3), "R6 programmed map",
                  int'(arr_queue), (7 - p) & 3);
        end

        // R9/R10: grant held while frame in progress
        do_reset();
        @(negedge clk);
        q_nonempty = 4'b0001;
        repeat (2) @(negedge clk);
        check(grant_valid && grant_q == 2'd0, "R10 grant to non-empty q0",
              int'(grant_q), 0);
        set_mode(3, 1'b1);
        q_nonempty = 4'b1001;
        repeat (4) @(negedge clk);
        check(grant_valid && grant_q == 2'd0, "R9 grant held until frame done",
              int'(grant_q), 0);
        push(3, "R9 next grant after frame done");
        run(4'b1001, "R9");

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule